// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit with HI/LO Accumulator

This unit runs the multiply and multiply-accumulate operations of a 64-bit integer pipeline. It keeps a 64-bit accumulator spread over two architectural registers, HI and LO. The low 32 bits of HI hold the upper half of the accumulator and the low 32 bits of LO hold its lower half. The issue stage raises `start` for one cycle with a decoded-format instruction word and two 64-bit source operands. Exactly two cycles later the unit pulses `done`. In that cycle it shows the updated HI and LO and, when the operation returns a result, a register-file write request.

Two function codes in the all-zero primary opcode space select the unit. The first covers nine variants, chosen by a 5-bit selector. The selector picks signed or unsigned operands, accumulate or restart from zero, and whether the high or low accumulator half goes back to the destination register. The second adds a signed product straight into the full 64-bit LO register. Any other selector under those two codes is reported as a reserved instruction and changes nothing.

Top module: `macc_unit`

## Requirements
- R1: While reset is held and directly after it, `hi_q` and `lo_q` read zero and `done`, `rsvd_op` and `rd_we` are low.
- R2: An operation belongs to the unit when instr[31:26] is 000000 and instr[5:0] is 101000 (main group) or 101001 (full-LO group). The destination index is instr[15:11] and the variant selector is instr[10:6]. Bits 25:16 and operand bits 63:32 have no effect on any result.
- R3: Under the main group, selectors 00100 (signed, low), 00101 (unsigned, low), 01100 (signed, high) and 01101 (unsigned, high) replace the accumulator with the 64-bit product of the operands' low 32 bits.
- R4: Under the main group, selector 00000 (signed, no write-back) and selectors 00010 (signed, low), 00011 (unsigned, low), 01010 (signed, high) and 01011 (unsigned, high) add the product to the accumulator, wrapping modulo 2^64.
- R5: The accumulator is read as {HI[31:0], LO[31:0]}, so HI[63:32] and LO[63:32] are ignored. Every accumulator write stores its upper half in HI and its lower half in LO, each with bits 63:32 copied from bit 31.
- R6: Signed variants treat the operand low words as two's complement and unsigned variants treat them as unsigned. `rd_data` is the selected 32-bit half of the updated accumulator, sign-extended to 64 bits for both kinds.
- R7: The full-LO group with selector 00000 sets LO to LO plus the sign-extended signed product over all 64 bits, leaves HI unchanged and keeps `rd_we` low.
- R8: Any other selector under either group raises `rsvd_op` for the single `done` cycle and leaves HI, LO and `rd_we` untouched.
- R9: A `start` accepted in cycle c gives a one-cycle `done` in cycle c+2. A `start` in cycle c+1 is ignored, and a `start` in the `done` cycle is accepted.
- R10: A write-back operation whose destination index is zero keeps `rd_we` low, while HI and LO are still updated.
- R11: An instruction outside both groups still completes with `done`, with `rsvd_op` and `rd_we` low and HI and LO unchanged. HI and LO never change outside a `done` cycle.
- R12: The early-product build (MUL_PIPE=1) and the late-product build (MUL_PIPE=0) behave identically at the ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when the unit is free |
| instr | input | 32 | Instruction word |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| done | output | 1 | One-cycle completion pulse |
| rsvd_op | output | 1 | Reserved-selector flag, valid with `done` |
| rd_we | output | 1 | Destination write enable, valid with `done` |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | DATA_W | Destination write data |
| hi_q | output | DATA_W | HI register |
| lo_q | output | DATA_W | LO register |

## Verification
The bench builds two copies side by side, both at DATA_W=64 and HALF_W=32. One copy forms the product in the launch cycle (MUL_PIPE=1) and the other forms it from registered operands one cycle later (MUL_PIPE=0). Both copies get the same stimulus and are compared against one independent model. This puts both generate branches of the multiplier under the same checks on the two-cycle timing, including a start that arrives while an operation is in flight and a start that lands in the done cycle. With 32-bit halves, the accumulator wrap, the all-ones unsigned product and the sign-filling of HI and LO hit their real boundary values.

// File: rtl/macc_pkg.sv
package macc_pkg;

   localparam int INSTR_W = 32;
   localparam int REG_IDX_W = 5;
   localparam int SEL_W = 5;

   localparam logic [5:0] OPC_SPECIAL = 6'b000000;
   localparam logic [5:0] FN_ACC_MAIN = 6'b101000;
   localparam logic [5:0] FN_ACC_LOFULL = 6'b101001;

   // Decoded micro-operation carried from issue to commit
   typedef struct packed {
      logic                 in_grp;    // instruction belongs to this unit
      logic                 rsvd;      // unknown selector under a known function
      logic                 full_lo;   // 64-bit LO-only accumulate
      logic                 sgn;       // signed operands
      logic                 accum;     // add to previous accumulator
      logic                 wb;        // returns a half to the register file
      logic                 hi_half;   // returned half is the upper one
      logic [REG_IDX_W-1:0] rd;
   } mop_t;

endpackage

// File: rtl/macc_decode.sv
module macc_decode
   import macc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output mop_t               op
);

   logic [5:0]       opc;
   logic [5:0]       fn;
   logic [SEL_W-1:0] sel;

   assign opc = instr[31:26];
   assign fn  = instr[5:0];
   assign sel = instr[10:6];

   always_comb begin
      op    = '0;
      op.rd = instr[15:11];
      if (opc == OPC_SPECIAL && fn == FN_ACC_MAIN) begin
         op.in_grp = 1'b1;
         case (sel)
            5'b00000: begin
               op.sgn   = 1'b1;
               op.accum = 1'b1;
            end
            5'b00010, 5'b00011, 5'b01010, 5'b01011: begin
               op.accum   = 1'b1;
               op.wb      = 1'b1;
               op.sgn     = ~sel[0];
               op.hi_half = sel[3];
            end
            5'b00100, 5'b00101, 5'b01100, 5'b01101: begin
               op.wb      = 1'b1;
               op.sgn     = ~sel[0];
               op.hi_half = sel[3];
            end
            default: op.rsvd = 1'b1;
         endcase
      end else if (opc == OPC_SPECIAL && fn == FN_ACC_LOFULL) begin
         op.in_grp = 1'b1;
         if (sel == '0) begin
            op.full_lo = 1'b1;
            op.sgn     = 1'b1;
            op.accum   = 1'b1;
         end else begin
            op.rsvd = 1'b1;
         end
      end
   end

endmodule

// File: rtl/macc_mult.sv
module macc_mult #(
   parameter int HALF_W   = 32,
   parameter bit MUL_PIPE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  sgn,
   input  logic [HALF_W-1:0]     a,
   input  logic [HALF_W-1:0]     b,
   output logic [2*HALF_W-1:0]   prod
);

   localparam int PROD_W = 2 * HALF_W;

   // Extend both words to product width, then multiply modulo 2^PROD_W
   function automatic logic [PROD_W-1:0] ext_mul(
      input logic              s,
      input logic [HALF_W-1:0] x,
      input logic [HALF_W-1:0] y
   );
      logic [PROD_W-1:0] xe;
      logic [PROD_W-1:0] ye;
      xe = {{(PROD_W-HALF_W){s & x[HALF_W-1]}}, x};
      ye = {{(PROD_W-HALF_W){s & y[HALF_W-1]}}, y};
      return xe * ye;
   endfunction

   generate
      if (MUL_PIPE) begin : g_early
         logic [PROD_W-1:0] prod_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  prod_q <= '0;
            else if (en) prod_q <= ext_mul(sgn, a, b);
         end
         assign prod = prod_q;
      end else begin : g_late
         logic              sgn_q;
         logic [HALF_W-1:0] a_q;
         logic [HALF_W-1:0] b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sgn_q <= 1'b0;
               a_q   <= '0;
               b_q   <= '0;
            end else if (en) begin
               sgn_q <= sgn;
               a_q   <= a;
               b_q   <= b;
            end
         end
         assign prod = ext_mul(sgn_q, a_q, b_q);
      end
   endgenerate

endmodule

// File: rtl/macc_acc.sv
module macc_acc
   import macc_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  commit,
   input  mop_t                  op,
   input  logic [2*HALF_W-1:0]   prod,
   output logic [DATA_W-1:0]     hi_q,
   output logic [DATA_W-1:0]     lo_q,
   output logic [DATA_W-1:0]     wb_val
);

   localparam int ACC_W = 2 * HALF_W;
   localparam int PAD_W = DATA_W - HALF_W;

   function automatic logic [DATA_W-1:0] widen(input logic [HALF_W-1:0] h);
      return {{PAD_W{h[HALF_W-1]}}, h};
   endfunction

   logic [ACC_W-1:0]  acc_cur;
   logic [ACC_W-1:0]  acc_nxt;
   logic [DATA_W-1:0] prod_wide;
   logic [DATA_W-1:0] lo_full_nxt;
   logic              apply;

   generate
      if (DATA_W > ACC_W) begin : g_pad
         assign prod_wide = {{(DATA_W-ACC_W){prod[ACC_W-1]}}, prod};
      end else begin : g_same
         assign prod_wide = prod;
      end
   endgenerate

   assign acc_cur     = {hi_q[HALF_W-1:0], lo_q[HALF_W-1:0]};
   assign acc_nxt     = op.accum ? (acc_cur + prod) : prod;
   assign lo_full_nxt = lo_q + prod_wide;
   assign apply       = commit && op.in_grp && !op.rsvd;
   assign wb_val      = widen(op.hi_half ? acc_nxt[ACC_W-1:HALF_W]
                                         : acc_nxt[HALF_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (apply) begin
         if (op.full_lo) begin
            lo_q <= lo_full_nxt;
         end else begin
            hi_q <= widen(acc_nxt[ACC_W-1:HALF_W]);
            lo_q <= widen(acc_nxt[HALF_W-1:0]);
         end
      end
   end

endmodule

// File: rtl/macc_unit.sv
module macc_unit
   import macc_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int HALF_W   = 32,
   parameter bit MUL_PIPE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [31:0]          instr,
   input  logic [DATA_W-1:0]    src_a,
   input  logic [DATA_W-1:0]    src_b,
   output logic                 done,
   output logic                 rsvd_op,
   output logic                 rd_we,
   output logic [4:0]           rd_idx,
   output logic [DATA_W-1:0]    rd_data,
   output logic [DATA_W-1:0]    hi_q,
   output logic [DATA_W-1:0]    lo_q
);

   localparam int ACC_W = 2 * HALF_W;

   generate
      if (DATA_W < ACC_W) begin : g_bad_width
         $error("macc_unit: DATA_W must hold two halves");
      end
      if (HALF_W < 2) begin : g_bad_half
         $error("macc_unit: HALF_W too small");
      end
   endgenerate

   mop_t              op_dec;
   mop_t              op_s1;
   logic              s1_vld;
   logic              accept;
   logic [ACC_W-1:0]  prod;
   logic [DATA_W-1:0] wb_val;

   assign accept = start && !s1_vld;

   macc_decode u_dec (
      .instr (instr),
      .op    (op_dec)
   );

   macc_mult #(
      .HALF_W   (HALF_W),
      .MUL_PIPE (MUL_PIPE)
   ) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (accept),
      .sgn   (op_dec.sgn),
      .a     (src_a[HALF_W-1:0]),
      .b     (src_b[HALF_W-1:0]),
      .prod  (prod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         op_s1  <= '0;
      end else begin
         s1_vld <= accept;
         if (accept) op_s1 <= op_dec;
      end
   end

   macc_acc #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (s1_vld),
      .op     (op_s1),
      .prod   (prod),
      .hi_q   (hi_q),
      .lo_q   (lo_q),
      .wb_val (wb_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         rsvd_op <= 1'b0;
         rd_we   <= 1'b0;
         rd_idx  <= '0;
         rd_data <= '0;
      end else begin
         done    <= s1_vld;
         rsvd_op <= s1_vld && op_s1.rsvd;
         rd_we   <= s1_vld && op_s1.wb && (op_s1.rd != '0);
         if (s1_vld) begin
            rd_idx  <= op_s1.rd;
            rd_data <= wb_val;
         end
      end
   end

endmodule

// File: rtl/macc_unit_chk.sv
module macc_unit_chk #(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              s1_vld,
   input logic              done,
   input logic              rsvd_op,
   input logic              rd_we,
   input logic [4:0]        rd_idx,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] hi_q,
   input logic [DATA_W-1:0] lo_q
);

   localparam int PAD_W = DATA_W - HALF_W;

   p_done_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start && !s1_vld |=> !done ##1 done);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_rsvd_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_op |-> done && !rd_we);

   p_rsvd_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_op |-> $stable(hi_q) && $stable(lo_q));

   p_quiet_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(hi_q) && $stable(lo_q));

   p_no_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> rd_idx != 5'd0);

   p_hi_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q[DATA_W-1:HALF_W] == {PAD_W{hi_q[HALF_W-1]}});

   p_wb_sign_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> rd_data[DATA_W-1:HALF_W] == {PAD_W{rd_data[HALF_W-1]}});

endmodule

bind macc_unit macc_unit_chk #(
   .DATA_W (DATA_W),
   .HALF_W (HALF_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .s1_vld  (s1_vld),
   .done    (done),
   .rsvd_op (rsvd_op),
   .rd_we   (rd_we),
   .rd_idx  (rd_idx),
   .rd_data (rd_data),
   .hi_q    (hi_q),
   .lo_q    (lo_q)
);

// File: tb/macc_unit_tb.sv
module macc_unit_tb;

   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   instr = '0;
   logic [DW-1:0] src_a = '0;
   logic [DW-1:0] src_b = '0;

   logic          done_e, rsvd_e, we_e;
   logic [4:0]    idx_e;
   logic [DW-1:0] data_e, hi_e, lo_e;
   logic          done_l, rsvd_l, we_l;
   logic [4:0]    idx_l;
   logic [DW-1:0] data_l, hi_l, lo_l;

   int n_checks = 0;
   int n_errors = 0;

   // model state and expectations
   logic [63:0] m_hi = '0;
   logic [63:0] m_lo = '0;
   logic        x_rsvd, x_we;
   logic [4:0]  x_idx;
   logic [63:0] x_data;

   always #4 clk = ~clk;

   macc_unit #(.DATA_W(64), .HALF_W(32), .MUL_PIPE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .src_a(src_a), .src_b(src_b), .done(done_e), .rsvd_op(rsvd_e),
      .rd_we(we_e), .rd_idx(idx_e), .rd_data(data_e), .hi_q(hi_e), .lo_q(lo_e)
   );

   macc_unit #(.DATA_W(64), .HALF_W(32), .MUL_PIPE(1'b0)) u_dut_late (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .src_a(src_a), .src_b(src_b), .done(done_l), .rsvd_op(rsvd_l),
      .rd_we(we_l), .rd_idx(idx_l), .rd_data(data_l), .hi_q(hi_l), .lo_q(lo_l)
   );

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rd,
                                      input logic [4:0] sel, input logic [5:0] fn);
      // rs/rt fields filled with a pattern that must not matter (R2)
      return {opc, 10'b1011010011, rd, sel, fn};
   endfunction

   function automatic logic [63:0] sx32(input logic [31:0] h);
      return {{32{h[31]}}, h};
   endfunction

   task automatic cmp(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cmp2(input string req, input string what, input logic [63:0] a_e,
                       input logic [63:0] a_l, input logic [63:0] exp);
      cmp(req, {what, " (early)"}, a_e, exp);
      cmp(req, {what, " (late) R12"}, a_l, exp);
   endtask

   // Independent model of one operation
   task automatic model(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b);
      logic [5:0]  opc, fn;
      logic [4:0]  sel;
      logic [63:0] sp, up, p, acc;
      logic        valid, uns, acc_mode, hi_sel;
      opc = ins[31:26];
      fn  = ins[5:0];
      sel = ins[10:6];
      sp  = sx32(a[31:0]) * sx32(b[31:0]);
      up  = {32'b0, a[31:0]} * {32'b0, b[31:0]};
      x_rsvd = 1'b0;
      x_we   = 1'b0;
      x_idx  = ins[15:11];
      x_data = '0;
      if (opc == 6'd0 && fn == 6'b101000) begin
         valid    = sel inside {5'd0, 5'd2, 5'd3, 5'd10, 5'd11, 5'd4, 5'd5, 5'd12, 5'd13};
         uns      = sel inside {5'd3, 5'd11, 5'd5, 5'd13};
         acc_mode = sel inside {5'd0, 5'd2, 5'd3, 5'd10, 5'd11};
         hi_sel   = sel inside {5'd10, 5'd11, 5'd12, 5'd13};
         if (!valid) begin
            x_rsvd = 1'b1;
         end else begin
            p   = uns ? up : sp;
            acc = {m_hi[31:0], m_lo[31:0]};
            acc = acc_mode ? acc + p : p;
            m_hi = sx32(acc[63:32]);
            m_lo = sx32(acc[31:0]);
            x_data = sx32(hi_sel ? acc[63:32] : acc[31:0]);
            x_we   = (sel != 5'd0) && (x_idx != 5'd0);
         end
      end else if (opc == 6'd0 && fn == 6'b101001) begin
         if (sel == 5'd0) m_lo = m_lo + sp;
         else             x_rsvd = 1'b1;
      end
   endtask

   task automatic check_done(input string req);
      cmp2(req, "done", 64'(done_e), 64'(done_l), 64'd1);
      cmp2(req, "rsvd_op", 64'(rsvd_e), 64'(rsvd_l), 64'(x_rsvd));
      cmp2(req, "rd_we", 64'(we_e), 64'(we_l), 64'(x_we));
      if (x_we) begin
         cmp2(req, "rd_idx", 64'(idx_e), 64'(idx_l), 64'(x_idx));
         cmp2(req, "rd_data", data_e, data_l, x_data);
      end
      cmp2(req, "hi", hi_e, hi_l, m_hi);
      cmp2(req, "lo", lo_e, lo_l, m_lo);
   endtask

   // launch, wait for the done cycle, then check the pulse has ended
   task automatic run_op(input string req, input logic [31:0] ins,
                         input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      start = 1'b1; instr = ins; src_a = a; src_b = b;
      model(ins, a, b);
      @(negedge clk);
      start = 1'b0;
      cmp2({req, " R9"}, "done early", 64'(done_e), 64'(done_l), 64'd0);
      @(negedge clk);
      check_done(req);
      @(negedge clk);
      cmp2({req, " R9"}, "done after pulse", 64'(done_e), 64'(done_l), 64'd0);
   endtask

   task automatic t_reset;
      cmp2("R1", "reset done", 64'(done_e), 64'(done_l), 64'd0);
      cmp2("R1", "reset rd_we", 64'(we_e), 64'(we_l), 64'd0);
      cmp2("R1", "reset rsvd", 64'(rsvd_e), 64'(rsvd_l), 64'd0);
      cmp2("R1", "reset hi", hi_e, hi_l, 64'd0);
      cmp2("R1", "reset lo", lo_e, lo_l, 64'd0);
   endtask

   task automatic t_multiply;
      // signed low / high with junk in upper operand words (R2, R3, R6)
      run_op("R3 R2 signed lo", mk(6'd0, 5'd7, 5'b00100, 6'b101000),
             64'hDEAD_BEEF_FFFF_FFFD, 64'h1234_5678_0000_0005);
      run_op("R3 signed hi", mk(6'd0, 5'd8, 5'b01100, 6'b101000),
             64'h0000_0000_8000_0000, 64'h0000_0000_0000_0003);
      // unsigned all-ones: lo half 1, hi half sign-extends (R6)
      run_op("R3 R6 unsigned lo", mk(6'd0, 5'd9, 5'b00101, 6'b101000),
             64'hFFFF_FFFF, 64'hFFFF_FFFF);
      run_op("R3 R6 unsigned hi", mk(6'd0, 5'd10, 5'b01101, 6'b101000),
             64'hAAAA_0000_FFFF_FFFF, 64'hFFFF_FFFF);
      cmp("R6", "unsigned hi rd_data", data_e, 64'hFFFF_FFFF_FFFF_FFFE);
   endtask

   task automatic t_accumulate;
      run_op("R3 set -1", mk(6'd0, 5'd1, 5'b00100, 6'b101000), 64'hFFFF_FFFF, 64'd1);
      cmp("R5", "hi after -1", hi_e, 64'hFFFF_FFFF_FFFF_FFFF);
      run_op("R4 wrap no-wb", mk(6'd0, 5'd3, 5'b00000, 6'b101000), 64'd1, 64'd1);
      cmp("R4", "wrapped lo", lo_e, 64'd0);
      run_op("R4 signed lo", mk(6'd0, 5'd4, 5'b00010, 6'b101000), 64'h7FFF_FFFF, 64'h7FFF_FFFF);
      run_op("R4 unsigned lo", mk(6'd0, 5'd5, 5'b00011, 6'b101000), 64'hF000_0000, 64'h10);
      run_op("R4 signed hi", mk(6'd0, 5'd6, 5'b01010, 6'b101000), 64'hFFFF_FF00, 64'h100);
      run_op("R4 unsigned hi", mk(6'd0, 5'd11, 5'b01011, 6'b101000), 64'hFFFF_FF00, 64'h100);
   endtask

   task automatic t_full_lo;
      run_op("R7 seed", mk(6'd0, 5'd2, 5'b01100, 6'b101000), 64'h4000_0000, 64'h10);
      run_op("R7 full-lo add", mk(6'd0, 5'd12, 5'b00000, 6'b101001), 64'h7FFF_FFFF, 64'hFFFF_FFFE);
      run_op("R7 full-lo add 2", mk(6'd0, 5'd12, 5'b00000, 6'b101001), 64'h4000_0000, 64'h4000_0000);
      // LO upper bits now differ from bit 31: the read must ignore them (R5)
      run_op("R5 acc after full-lo", mk(6'd0, 5'd13, 5'b00010, 6'b101000), 64'd3, 64'd5);
   endtask

   task automatic t_reserved;
      run_op("R8 main sel 00001", mk(6'd0, 5'd14, 5'b00001, 6'b101000), 64'd9, 64'd9);
      run_op("R8 main sel 11111", mk(6'd0, 5'd14, 5'b11111, 6'b101000), 64'd9, 64'd9);
      run_op("R8 full-lo sel 00100", mk(6'd0, 5'd14, 5'b00100, 6'b101001), 64'd9, 64'd9);
   endtask

   task automatic t_rd_zero;
      run_op("R10 rd zero", mk(6'd0, 5'd0, 5'b00100, 6'b101000), 64'd6, 64'd7);
      cmp("R10", "lo updated", lo_e, 64'd42);
   endtask

   task automatic t_outside;
      run_op("R11 other opcode", mk(6'd4, 5'd3, 5'b00100, 6'b101000), 64'd2, 64'd2);
      run_op("R11 other function", mk(6'd0, 5'd3, 5'b00100, 6'b100000), 64'd2, 64'd2);
   endtask

   task automatic t_busy;
      // second start while in flight is ignored
      @(negedge clk);
      start = 1'b1; instr = mk(6'd0, 5'd15, 5'b00100, 6'b101000);
      src_a = 64'd3; src_b = 64'd4;
      model(instr, src_a, src_b);
      @(negedge clk);
      instr = mk(6'd0, 5'd16, 5'b00101, 6'b101000); src_a = 64'd100; src_b = 64'd100;
      @(negedge clk);
      start = 1'b0;
      check_done("R9 in-flight first");
      @(negedge clk);
      cmp2("R9", "ignored start no done", 64'(done_e), 64'(done_l), 64'd0);
      @(negedge clk);
      cmp2("R9", "ignored start no done 2", 64'(done_e), 64'(done_l), 64'd0);
      cmp2("R9", "ignored start lo", lo_e, lo_l, 64'd12);
      // start in the done cycle is accepted
      start = 1'b1; instr = mk(6'd0, 5'd17, 5'b00010, 6'b101000);
      src_a = 64'd2; src_b = 64'd5;
      model(instr, src_a, src_b);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check_done("R9 first back-to-back");
      start = 1'b1; instr = mk(6'd0, 5'd18, 5'b01101, 6'b101000);
      src_a = 64'hFFFF_FFFF; src_b = 64'd2;
      model(instr, src_a, src_b);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check_done("R9 start in done cycle");
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_multiply();
      t_accumulate();
      t_full_lo();
      t_reserved();
      t_rd_zero();
      t_outside();
      t_busy();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule